// File: doc/BRIEF.md
# Frame Sequence Gap Monitor

This block watches the payload of every frame that an upstream checker has already validated. It takes the first four payload bytes as a 32-bit sequence number, most significant byte first. It compares that number with the one it expects, which is one more than the last number accepted. When frames are missing it adds the size of the hole to a running loss total. A sink can then tell lost frames on the link apart from a producer that has stopped, because a stalled producer leaves the count unchanged while lost frames make it grow.

Payload bytes arrive one at a time with a valid qualifier, and a marker flags the first byte of each payload. A single-cycle frame-accepted strobe closes the frame, and the decision is taken on that strobe. After reset the first complete frame only sets the starting point. A number that moves backwards counts as a producer restart and never as loss. A payload that is too short to carry the number is set aside and flagged.

Top module: `seq_gap_monitor`

## Requirements
- R1: While reset is low and on the first cycle after it, lastSeq and dropCount read 0, seqKnown reads 0, and gapPulse, restartPulse and shortPulse are low.
- R2: The sequence number is built from the first four bytes that have payloadValid high, counting from a byte with payloadFirst high, in big-endian order (first byte = bits 31:24). Bytes after the fourth, cycles with payloadValid low, and bytes that arrive before any payloadFirst are ignored.
- R3: The first frame with at least four bytes after reset loads lastSeq with its number, sets seqKnown to 1, and leaves dropCount unchanged with no pulse.
- R4: A frame whose number equals lastSeq + 1 updates lastSeq and raises no pulse and leaves dropCount unchanged, so a gap-free run keeps dropCount at zero.
- R5: When d = (received − (lastSeq + 1)) mod 2^32 lies in 1 to 2^31−1, dropCount increases by d, lastSeq takes the received value, and gapPulse is high for one cycle.
- R6: When d lies in 2^31 to 2^32−1 (a backward jump), restartPulse is high for one cycle, lastSeq takes the received value, and dropCount is unchanged.
- R7: All sequence arithmetic wraps modulo 2^32, so 0xFFFFFFFF followed by 0x00000000 is a consecutive pair.
- R8: dropCount saturates at 0xFFFFFFFF and stays there.
- R9: A frame with fewer than four counted bytes raises shortPulse for one cycle and changes neither lastSeq, dropCount nor seqKnown. A short frame right after reset does not set the starting point.
- R10: The outputs reflect a frame on the cycle after the clock edge that samples frameOk. Each pulse lasts exactly one cycle, and at most one pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| payloadValid | input | 1 | payloadByte carries a payload byte this cycle |
| payloadFirst | input | 1 | Marks the first byte of a payload (qualified by payloadValid) |
| payloadByte | input | 8 | Payload byte |
| frameOk | input | 1 | One-cycle strobe: the frame whose bytes were just streamed is valid |
| lastSeq | output | 32 | Last sequence number accepted |
| seqKnown | output | 1 | A starting sequence has been taken since reset |
| dropCount | output | 32 | Saturating total of missing frames |
| gapPulse | output | 1 | A forward gap was counted |
| restartPulse | output | 1 | The sequence moved backwards |
| shortPulse | output | 1 | A frame had too few bytes to carry a sequence number |

## Verification
The bench targets the places where a tracker typically goes wrong. A monitor that charged the first frame as a loss would show a huge count right after reset. One that treated a backward jump as a gap would add an enormous wrapped distance to the loss count. One that ignored wrap-around would report a restart or a huge gap at 0xFFFFFFFF → 0. One that let the counter roll over would drop to a small value after saturation. Short frames, stray bytes before a first marker, and bytes beyond the fourth are fed to catch a tracker that read junk into the sequence field. Bubbles inside a payload are fed to catch one that shifted on invalid cycles.

// File: rtl/seqmon_pkg.sv
package seqmon_pkg;

  // Strobes the control issues to the datapath each cycle.
  typedef struct packed {
    logic loadFirst;  // start a new capture with this byte
    logic shiftIn;    // append this byte to the capture
    logic doInit;     // take the captured value as starting point
    logic doCheck;    // compare captured value with expectation
    logic doShort;    // frame too short, flag only
  } ctrlStrobes_t;

endpackage

// File: rtl/seqmon_ctrl.sv
module seqmon_ctrl
  import seqmon_pkg::*;
#(
  parameter int SEQ_BYTES = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         payloadValid,
  input  logic         payloadFirst,
  input  logic         frameOk,
  output ctrlStrobes_t strb,
  output logic         primed
);

  localparam int CW = $clog2(SEQ_BYTES + 1);
  localparam logic [CW-1:0] FULL = CW'(SEQ_BYTES);

  logic [CW-1:0] byteCnt;
  logic          haveAll;

  assign haveAll = (byteCnt == FULL);

  always_comb begin
    strb           = '0;
    strb.loadFirst = payloadValid && payloadFirst;
    // only extend a capture that was opened by a first-byte marker
    strb.shiftIn   = payloadValid && !payloadFirst &&
                     (byteCnt != '0) && (byteCnt < FULL);
    strb.doShort   = frameOk && !haveAll;
    strb.doInit    = frameOk && haveAll && !primed;
    strb.doCheck   = frameOk && haveAll && primed;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      primed  <= 1'b0;
    end else begin
      if (frameOk)             byteCnt <= '0;
      else if (strb.loadFirst) byteCnt <= CW'(1);
      else if (strb.shiftIn)   byteCnt <= byteCnt + CW'(1);
      if (strb.doInit)         primed  <= 1'b1;
    end
  end

  // R2: the capture never counts beyond the sequence field
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= FULL);

  // R3: once a starting point is taken it stays until reset
  p_primed_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    primed |=> primed);

  // R9: a short frame never sets the starting point
  p_short_no_prime_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doShort && !primed) |=> !primed);

endmodule

// File: rtl/seqmon_dp.sv
module seqmon_dp
  import seqmon_pkg::*;
#(
  parameter int SEQ_W  = 32,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] payloadByte,
  input  ctrlStrobes_t      strb,
  output logic [SEQ_W-1:0]  lastSeq,
  output logic [CNT_W-1:0]  dropCount,
  output logic              gapPulse,
  output logic              restartPulse,
  output logic              shortPulse
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SEQ_W-1:0] capReg;
  logic [SEQ_W-1:0] expected;
  logic [SEQ_W-1:0] delta;
  logic             isAhead;
  logic             isBehind;
  logic [CNT_W:0]   sumWide;
  logic [CNT_W-1:0] dropNext;

  // big-endian capture of the sequence field
  always_ff @(posedge clk) begin
    if (!rstN)               capReg <= '0;
    else if (strb.loadFirst) capReg <= SEQ_W'(payloadByte);
    else if (strb.shiftIn)   capReg <= {capReg[SEQ_W-BYTE_W-1:0], payloadByte};
  end

  // modulo distance from the expected value; the top bit splits
  // forward gaps from backward jumps
  always_comb begin
    expected = lastSeq + SEQ_W'(1);
    delta    = capReg - expected;
    isAhead  = strb.doCheck && (delta != '0) && !delta[SEQ_W-1];
    isBehind = strb.doCheck && delta[SEQ_W-1];
    sumWide  = {1'b0, dropCount} + (CNT_W+1)'(delta);
    dropNext = sumWide[CNT_W] ? CNT_MAX : sumWide[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSeq      <= '0;
      dropCount    <= '0;
      gapPulse     <= 1'b0;
      restartPulse <= 1'b0;
      shortPulse   <= 1'b0;
    end else begin
      gapPulse     <= isAhead;
      restartPulse <= isBehind;
      shortPulse   <= strb.doShort;
      if (strb.doInit || strb.doCheck) lastSeq <= capReg;
      if (isAhead) dropCount <= dropNext;
    end
  end

  // R4: the loss total never goes down
  p_drop_monotonic_r4: assert property (@(posedge clk) disable iff (!rstN)
    dropCount >= $past(dropCount));

  // R6: a restart leaves the loss total alone
  p_restart_keeps_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    restartPulse |-> dropCount == $past(dropCount));

  // R5: a gap below saturation strictly raises the loss total
  p_gap_raises_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (gapPulse && $past(dropCount) != CNT_MAX) |-> dropCount > $past(dropCount));

  // R8: once saturated the counter stays at its maximum
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dropCount) == CNT_MAX) |-> dropCount == CNT_MAX);

  // R9: a short frame leaves the tracked sequence untouched
  p_short_keeps_seq_r9: assert property (@(posedge clk) disable iff (!rstN)
    shortPulse |-> lastSeq == $past(lastSeq));

  // R10: at most one event pulse per cycle
  p_pulse_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({gapPulse, restartPulse, shortPulse}));

endmodule

// File: rtl/seq_gap_monitor.sv
module seq_gap_monitor
  import seqmon_pkg::*;
#(
  parameter int SEQ_W  = 32,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              payloadValid,
  input  logic              payloadFirst,
  input  logic [BYTE_W-1:0] payloadByte,
  input  logic              frameOk,
  output logic [SEQ_W-1:0]  lastSeq,
  output logic              seqKnown,
  output logic [CNT_W-1:0]  dropCount,
  output logic              gapPulse,
  output logic              restartPulse,
  output logic              shortPulse
);

  localparam int SEQ_BYTES = SEQ_W / BYTE_W;

  ctrlStrobes_t strb;

  seqmon_ctrl #(.SEQ_BYTES(SEQ_BYTES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .payloadValid (payloadValid),
    .payloadFirst (payloadFirst),
    .frameOk      (frameOk),
    .strb         (strb),
    .primed       (seqKnown)
  );

  seqmon_dp #(.SEQ_W(SEQ_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .payloadByte  (payloadByte),
    .strb         (strb),
    .lastSeq      (lastSeq),
    .dropCount    (dropCount),
    .gapPulse     (gapPulse),
    .restartPulse (restartPulse),
    .shortPulse   (shortPulse)
  );

endmodule

// File: tb/sim_seq_gap_monitor.sv
`timescale 1ns/1ps
module sim_seq_gap_monitor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        payloadValid = 1'b0;
  logic        payloadFirst = 1'b0;
  logic [7:0]  payloadByte = 8'h00;
  logic        frameOk = 1'b0;
  logic [31:0] lastSeq;
  logic        seqKnown;
  logic [31:0] dropCount;
  logic        gapPulse, restartPulse, shortPulse;

  int nChecks = 0;
  int nFails  = 0;
  logic sGap, sRst, sShort;

  always #2.5 clk = ~clk;

  seq_gap_monitor u0 (
    .clk(clk), .rstN(rstN), .payloadValid(payloadValid),
    .payloadFirst(payloadFirst), .payloadByte(payloadByte), .frameOk(frameOk),
    .lastSeq(lastSeq), .seqKnown(seqKnown), .dropCount(dropCount),
    .gapPulse(gapPulse), .restartPulse(restartPulse), .shortPulse(shortPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; payloadValid = 1'b0; payloadFirst = 1'b0; frameOk = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Streams n payload bytes (sequence field first), optional bubbles,
  // then strobes frameOk and samples the result one edge later.
  task automatic sendFrame(input logic [31:0] s, input int n, input bit bubbles,
                           input bit withFirst);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      payloadValid = 1'b1;
      payloadFirst = withFirst && (i == 0);
      payloadByte  = (i < 4) ? s[31-8*i -: 8] : 8'hA0 + 8'(i);
      if (bubbles) begin
        @(negedge clk);
        payloadValid = 1'b0; payloadFirst = 1'b0; payloadByte = 8'hEE;
      end
    end
    @(negedge clk);
    payloadValid = 1'b0; payloadFirst = 1'b0; frameOk = 1'b1;
    @(posedge clk); #1;
    sGap = gapPulse; sRst = restartPulse; sShort = shortPulse;
    @(negedge clk);
    frameOk = 1'b0;
    @(posedge clk); #1;
    chk("R10 pulses one cycle", {29'd0, gapPulse, restartPulse, shortPulse}, 32'd0);
  endtask

  task automatic expectState(input string req, input logic [31:0] seq,
                             input logic [31:0] drop, input bit g, input bit r, input bit sh);
    chk({req, " lastSeq"}, lastSeq, seq);
    chk({req, " dropCount"}, dropCount, drop);
    chk({req, " pulses"}, {29'd0, sGap, sRst, sShort}, {29'd0, g, r, sh});
  endtask

  task automatic testReset();
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    chk("R1 lastSeq in reset", lastSeq, 32'd0);
    chk("R1 dropCount in reset", dropCount, 32'd0);
    chk("R1 seqKnown in reset", {31'd0, seqKnown}, 32'd0);
    chk("R1 pulses in reset", {29'd0, gapPulse, restartPulse, shortPulse}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 dropCount after reset", dropCount, 32'd0);
  endtask

  task automatic testFirstAndRun();
    doReset();
    sendFrame(32'h12345678, 7, 1'b0, 1'b1);
    expectState("R3 R2 first frame", 32'h12345678, 32'd0, 0, 0, 0);
    chk("R3 seqKnown", {31'd0, seqKnown}, 32'd1);
    for (int k = 1; k <= 3; k++) begin
      sendFrame(32'h12345678 + 32'(k), 4 + k, k == 2, 1'b1);
      expectState("R4 R2 consecutive", 32'h12345678 + 32'(k), 32'd0, 0, 0, 0);
    end
  endtask

  task automatic testGapRestartShort();
    sendFrame(32'h12345680, 4, 1'b0, 1'b1);
    expectState("R5 gap of 4", 32'h12345680, 32'd4, 1, 0, 0);
    sendFrame(32'h12345681, 4, 1'b0, 1'b1);
    expectState("R4 after gap", 32'h12345681, 32'd4, 0, 0, 0);
    sendFrame(32'h00000010, 5, 1'b1, 1'b1);
    expectState("R6 restart", 32'h00000010, 32'd4, 0, 1, 0);
    sendFrame(32'h00000011, 4, 1'b0, 1'b1);
    expectState("R6 after restart", 32'h00000011, 32'd4, 0, 0, 0);
    sendFrame(32'h99999999, 3, 1'b0, 1'b1);
    expectState("R9 short frame", 32'h00000011, 32'd4, 0, 0, 1);
    sendFrame(32'h77777777, 6, 1'b0, 1'b0);
    expectState("R2 no first marker", 32'h00000011, 32'd4, 0, 0, 1);
    sendFrame(32'h00000012, 4, 1'b0, 1'b1);
    expectState("R9 R4 after short", 32'h00000012, 32'd4, 0, 0, 0);
  endtask

  task automatic testWrap();
    doReset();
    sendFrame(32'hFFFFFFFF, 4, 1'b0, 1'b1);
    expectState("R7 init at max", 32'hFFFFFFFF, 32'd0, 0, 0, 0);
    sendFrame(32'h00000000, 4, 1'b0, 1'b1);
    expectState("R7 wrap consecutive", 32'h00000000, 32'd0, 0, 0, 0);
  endtask

  task automatic testSaturate();
    doReset();
    sendFrame(32'h00000000, 4, 1'b0, 1'b1);
    sendFrame(32'h80000000, 4, 1'b0, 1'b1);
    expectState("R5 large gap", 32'h80000000, 32'h7FFFFFFF, 1, 0, 0);
    sendFrame(32'h00000000, 4, 1'b0, 1'b1);
    expectState("R7 R5 forward across wrap", 32'h00000000, 32'hFFFFFFFE, 1, 0, 0);
    sendFrame(32'h00000003, 4, 1'b0, 1'b1);
    expectState("R8 saturate", 32'h00000003, 32'hFFFFFFFF, 1, 0, 0);
    sendFrame(32'h00000010, 4, 1'b0, 1'b1);
    expectState("R8 stays saturated", 32'h00000010, 32'hFFFFFFFF, 1, 0, 0);
  endtask

  task automatic testShortFirst();
    doReset();
    sendFrame(32'h55555555, 2, 1'b0, 1'b1);
    expectState("R9 short after reset", 32'd0, 32'd0, 0, 0, 1);
    chk("R9 short does not prime", {31'd0, seqKnown}, 32'd0);
    sendFrame(32'h00001000, 4, 1'b0, 1'b1);
    expectState("R3 init after short", 32'h00001000, 32'd0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testFirstAndRun();
    testGapRestartShort();
    testWrap();
    testSaturate();
    testShortFirst();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule